// File: doc/BRIEF.md
# Pipelined Burst Synchronous SRAM

This block is a synthesizable synchronous static memory with a 32-bit data path split into four 8-bit lanes. Reads pass through a pipeline, so a burst returns one word per clock after a fixed start-up delay. The address, chip select, access strobe, lane enables, global write enable and write data are all captured on the rising clock edge. The output enable and the sleep input act on the output driver without waiting for a clock.

An access begins on an edge where the strobe is low and the chip select is low. The address given with it becomes the base of a four-word burst. On each later edge with the strobe high, the burst counter advances and the next word of the group is read or written, whatever the chip select does. The order within the group is either linear or interleaved. Holding the strobe low with the chip select high deselects the block. A high sleep input puts the block in standby. Instead of a real three-state pin, the bus is modelled as a data output plus a drive-enable output.

Top module: `pbsram`

## Requirements
- R1: While reset is applied and right after it is released, `dq_drive` is low and `dq_out` is zero, even with `oe_n` low.
- R2: An edge with `start_n` low and `ce_n` high, and `sleep` low on that edge and the one before, deselects the block. All read data still in the pipeline is discarded, so `dq_drive` stays low afterwards until a new read comes through.
- R3: A read accepted on edge k is driven on `dq_out` from just after edge k+2 until edge k+3, with `dq_drive` high while `oe_n` is low. Each later accepted read comes out one clock after the one before it.
- R4: While a burst is open, each edge with `start_n` high advances it by one word, whether `ce_n` is high or low.
- R5: With `mode_ilv` low, beat n of a burst that starts at address A uses address {A[AW-1:2], (A[1:0]+n) mod 4}. The upper address bits never change, and the order wraps after four beats.
- R6: With `mode_ilv` high, beat n uses address {A[AW-1:2], A[1:0] XOR (n mod 4)}.
- R7: An access is a write only when `wen_n` is low and at least one bit of `lane_n` is low. Each low bit i of `lane_n` writes only bits 8i+7:8i of `wdata` into that lane, on the same edge as the access.
- R8: An access with `wen_n` high, or with all four bits of `lane_n` high, is a read and leaves the memory unchanged.
- R9: `oe_n` acts without a clock: `dq_drive` follows it in the same cycle while read data is ready.
- R10: An accepted write discards all read data still in the pipeline, so the bus is not driven after a write edge.
- R11: While `sleep` is high, no access is taken, the pipeline is emptied and the open burst is closed. The first edge with `sleep` low is also ignored, and the edge after it accepts an access.
- R12: An edge with `start_n` high and no open burst (after reset, a deselect or standby) does nothing: no memory write and no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | AW | Word address, captured when a burst starts |
| ce_n | input | 1 | Chip select, active low, used only when the strobe is low |
| start_n | input | 1 | Access strobe, active low; high continues the open burst |
| wen_n | input | 1 | Global write enable, active low |
| lane_n | input | NB | Per-lane write enables, active low; bit i covers bits 8i+7:8i |
| wdata | input | 8*NB | Write data |
| oe_n | input | 1 | Output enable, active low, acts without a clock |
| mode_ilv | input | 1 | Burst order: 0 linear, 1 interleaved |
| sleep | input | 1 | Standby request, active high |
| dq_out | output | 8*NB | Read data, zero when not driven |
| dq_drive | output | 1 | High while the block drives the data bus |

## Verification
A write beat can land on the same edge at which an earlier read is still moving through the pipeline. The bench provokes this by starting a write on the edge right after a read begins. It also starts writes while a burst read is still returning words. Its scoreboard drops every pending expected word at that write edge and then requires a quiet bus on each following cycle. A later read of the written address confirms that the write itself took effect.

// File: rtl/pbsram.sv
module pbsram #(
  parameter int AW = 6,
  parameter int NB = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     addr,
  input  logic              ce_n,
  input  logic              start_n,
  input  logic              wen_n,
  input  logic [NB-1:0]     lane_n,
  input  logic [8*NB-1:0]   wdata,
  input  logic              oe_n,
  input  logic              mode_ilv,
  input  logic              sleep,
  output logic [8*NB-1:0]   dq_out,
  output logic              dq_drive
);
  localparam int DW    = 8 * NB;
  localparam int DEPTH = 1 << AW;

  logic [NB-1:0][7:0] mem [DEPTH];

  logic          slp_q, b_act;
  logic [AW-1:0] b_base;
  logic [1:0]    b_cnt, nxt_cnt, low;
  logic          go, begin_acc, desel, cont, is_wr, acc, rd_acc, wr_acc, flush;
  logic [AW-1:0] cur_addr;
  logic          r1_vld, r2_vld, q_vld;
  logic [AW-1:0] r1_addr;
  logic [DW-1:0] r2_data, q_data;

  assign go        = ~sleep & ~slp_q;
  assign begin_acc = go & ~start_n & ~ce_n;
  assign desel     = go & ~start_n & ce_n;
  assign cont      = go & start_n & b_act;
  assign is_wr     = ~wen_n & ~(&lane_n);
  assign acc       = begin_acc | cont;
  assign rd_acc    = acc & ~is_wr;
  assign wr_acc    = acc & is_wr;
  assign flush     = sleep | desel | wr_acc;

  assign nxt_cnt  = b_cnt + 2'd1;
  assign low      = mode_ilv ? (b_base[1:0] ^ nxt_cnt) : (b_base[1:0] + nxt_cnt);
  assign cur_addr = begin_acc ? addr : {b_base[AW-1:2], low};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slp_q  <= 1'b0;
      b_act  <= 1'b0;
      b_base <= '0;
      b_cnt  <= '0;
    end else begin
      slp_q <= sleep;
      if (sleep | desel) begin
        b_act <= 1'b0;
      end else if (begin_acc) begin
        b_act  <= 1'b1;
        b_base <= addr;
        b_cnt  <= '0;
      end else if (cont) begin
        b_cnt <= nxt_cnt;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr_acc) begin
      for (int i = 0; i < NB; i++) begin
        if (!lane_n[i]) mem[cur_addr][i] <= wdata[8*i +: 8];
      end
    end
    r1_addr <= cur_addr;
    r2_data <= mem[r1_addr];
    q_data  <= r2_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r1_vld <= 1'b0;
      r2_vld <= 1'b0;
      q_vld  <= 1'b0;
    end else if (flush) begin
      r1_vld <= 1'b0;
      r2_vld <= 1'b0;
      q_vld  <= 1'b0;
    end else begin
      r1_vld <= rd_acc;
      r2_vld <= r1_vld;
      q_vld  <= r2_vld;
    end
  end

  assign dq_drive = q_vld & ~oe_n & ~sleep;
  assign dq_out   = dq_drive ? q_data : '0;
endmodule

// File: rtl/pbsram_chk.sv
module pbsram_chk #(
  parameter int NB = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_n,
  input logic          ce_n,
  input logic          wen_n,
  input logic [NB-1:0] lane_n,
  input logic          sleep,
  input logic          dq_drive,
  input logic          rd_acc
);
  AST_DESEL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_n && ce_n) |=> !dq_drive); // R2

  AST_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_n && !ce_n && !wen_n && !(&lane_n)) |=> !dq_drive); // R10

  AST_WAKE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sleep) |=> !dq_drive); // R11

  AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    dq_drive |-> $past(rd_acc, 3)); // R3

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |=> !dq_drive); // R1
endmodule

bind pbsram pbsram_chk #(.NB(NB)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start_n  (start_n),
  .ce_n     (ce_n),
  .wen_n    (wen_n),
  .lane_n   (lane_n),
  .sleep    (sleep),
  .dq_drive (dq_drive),
  .rd_acc   (rd_acc)
);

// File: tb/pbsram_tb.sv
module pbsram_tb;
  localparam int PER = 10;
  localparam int AW  = 6;
  localparam int NB  = 4;
  localparam int DW  = 8 * NB;

  logic clk = 1'b0;
  logic rst_n;
  logic [AW-1:0] addr;
  logic ce_n, start_n, wen_n, oe_n, mode_ilv, sleep;
  logic [NB-1:0] lane_n;
  logic [DW-1:0] wdata, dq_out;
  logic dq_drive;

  pbsram #(.AW(AW), .NB(NB)) u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .ce_n(ce_n), .start_n(start_n),
    .wen_n(wen_n), .lane_n(lane_n), .wdata(wdata), .oe_n(oe_n),
    .mode_ilv(mode_ilv), .sleep(sleep), .dq_out(dq_out), .dq_drive(dq_drive)
  );

  always #(PER/2) clk = ~clk;

  int total = 0, bad = 0, cyc = 0;
  bit done = 0, mon_en = 0;
  string cur_tag = "R1";

  logic [DW-1:0] model [1<<AW];
  logic b_act = 0, slp = 0, slp_q = 0, md = 0;
  logic [AW-1:0] b_base = '0;
  logic [1:0] b_cnt = '0;

  int            due_q [$];
  logic [DW-1:0] dat_q [$];
  string         tag_q [$];

  task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic logic [DW-1:0] pat(input int a);
    return 32'h1357_9BDF ^ (a * 32'h0103_0507);
  endfunction

  task automatic step(input logic s_n, input logic c_n, input logic w_n, input logic [NB-1:0] b_n,
                      input logic [AW-1:0] a, input logic [DW-1:0] d);
    logic go, beg, des, cont, wr;
    logic [1:0] nc;
    logic [AW-1:0] ca;
    @(negedge clk);
    start_n = s_n; ce_n = c_n; wen_n = w_n; lane_n = b_n; addr = a; wdata = d;
    sleep = slp; mode_ilv = md;
    go   = !slp && !slp_q;
    beg  = go && !s_n && !c_n;
    des  = go && !s_n && c_n;
    cont = go && s_n && b_act;
    wr   = !w_n && (b_n != '1);
    nc   = b_cnt + 2'd1;
    ca   = beg ? a : {b_base[AW-1:2], md ? (b_base[1:0] ^ nc) : (b_base[1:0] + nc)};
    if (slp || des || ((beg || cont) && wr)) begin
      due_q.delete(); dat_q.delete(); tag_q.delete();
    end
    if ((beg || cont) && wr) begin
      for (int i = 0; i < NB; i++)
        if (!b_n[i]) model[ca][8*i +: 8] = d[8*i +: 8];
    end
    if ((beg || cont) && !wr && mon_en) begin
      due_q.push_back(cyc + 3); dat_q.push_back(model[ca]); tag_q.push_back(cur_tag);
    end
    if (slp || des) b_act = 0;
    else if (beg) begin b_act = 1; b_base = a; b_cnt = 0; end
    else if (cont) b_cnt = nc;
    @(posedge clk);
    slp_q = slp;
  endtask

  task automatic rd_burst(input logic [AW-1:0] a, input int n);
    step(0, 0, 1, '1, a, '0);
    repeat (n) step(1, 1, 1, '1, '0, '0);
    step(0, 1, 1, '1, '0, '0);
  endtask

  // scoreboard monitor
  always @(posedge clk) begin
    cyc++;
    #1;
    if (mon_en && rst_n) begin
      if (due_q.size() > 0 && due_q[0] == cyc) begin
        chk(dq_drive && dq_out == dat_q[0], tag_q[0], dq_out, dat_q[0]);
        void'(due_q.pop_front()); void'(dat_q.pop_front()); void'(tag_q.pop_front());
      end else begin
        chk(!dq_drive, cur_tag, {31'b0, dq_drive}, '0);
      end
    end
  end

  initial begin
    #(PER * 50000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; start_n = 1; ce_n = 1; wen_n = 1; lane_n = '1; addr = '0; wdata = '0;
    oe_n = 0; mode_ilv = 0; sleep = 0;
    repeat (3) @(posedge clk);
    #1 chk(!dq_drive && dq_out == '0, "R1", dq_out, '0);
    @(negedge clk) rst_n = 1;
    @(posedge clk); #1 chk(!dq_drive && dq_out == '0, "R1", dq_out, '0);
    mon_en = 1;

    // R7: fill memory with full-word linear write bursts
    cur_tag = "R7"; md = 0;
    for (int b = 0; b < (1 << AW); b += 4) begin
      step(0, 0, 0, '0, b[AW-1:0], pat(b));
      for (int i = 1; i < 4; i++) step(1, 1, 0, '0, '0, pat(b + i));
    end
    step(0, 1, 1, '1, '0, '0);

    // R3: back-to-back single reads, then a short continuation to drain
    cur_tag = "R3";
    step(0, 0, 1, '1, 6'd5, '0);
    step(0, 0, 1, '1, 6'd17, '0);
    step(0, 0, 1, '1, 6'd40, '0);
    repeat (3) step(1, 0, 1, '1, '0, '0);
    step(0, 1, 1, '1, '0, '0);

    // R5 + R4: linear burst from low bits 2, chip select high on beats
    cur_tag = "R5"; md = 0;
    rd_burst(6'd6, 6);
    cur_tag = "R4";
    rd_burst(6'd13, 5);

    // R6: interleaved burst with wrap past four beats
    cur_tag = "R6"; md = 1;
    rd_burst(6'd9, 7);
    rd_burst(6'd46, 5);
    md = 0;

    // R7: lanes 0 and 2 written only (lane_n = 4'b1010)
    cur_tag = "R7";
    step(0, 0, 0, 4'b1010, 6'd20, 32'hDEAD_BEEF);
    step(0, 0, 0, 4'b0111, 6'd23, 32'hA1B2_C3D4);
    step(0, 1, 1, '1, '0, '0);
    rd_burst(6'd20, 5);

    // R8: write qualifiers off -> reads, memory untouched
    cur_tag = "R8";
    step(0, 0, 0, '1, 6'd21, 32'hFFFF_FFFF);
    step(0, 0, 1, '0, 6'd22, 32'h0000_0000);
    repeat (3) step(1, 1, 1, '1, '0, '0);
    step(0, 1, 1, '1, '0, '0);
    rd_burst(6'd21, 4);

    // R10: write on the edge after a read begins flushes the pending word
    cur_tag = "R10";
    step(0, 0, 1, '1, 6'd30, '0);
    step(0, 0, 0, '0, 6'd31, 32'h0BAD_F00D);
    step(1, 1, 0, 4'b1100, '0, 32'h5555_AAAA);
    step(0, 0, 1, '1, 6'd28, '0);
    step(1, 1, 0, '0, '0, 32'h7777_8888);
    repeat (2) step(1, 1, 1, '1, '0, '0);
    step(0, 1, 1, '1, '0, '0);
    rd_burst(6'd28, 5);

    // R2: deselect right after a read drops its data
    cur_tag = "R2";
    step(0, 0, 1, '1, 6'd33, '0);
    step(0, 1, 1, '1, '0, '0);
    repeat (3) step(0, 1, 0, '0, 6'd34, 32'h1111_2222);

    // R12: strobe high with no open burst does nothing
    cur_tag = "R12";
    repeat (2) step(1, 0, 0, '0, 6'd34, 32'hFFFF_0000);
    rd_burst(6'd33, 4);

    // R11: standby drops data, ignores access, wake edge ignored
    cur_tag = "R11";
    step(0, 0, 1, '1, 6'd40, '0);
    slp = 1;
    step(0, 0, 0, '0, 6'd41, 32'hCAFE_0001);
    step(1, 1, 1, '1, '0, '0);
    slp = 0;
    step(0, 0, 0, '0, 6'd42, 32'hCAFE_0002);
    step(0, 0, 0, '0, 6'd43, 32'hCAFE_0003);
    step(0, 1, 1, '1, '0, '0);
    rd_burst(6'd40, 5);

    // R9: output enable acts within the cycle
    cur_tag = "R9"; mon_en = 0;
    @(negedge clk) oe_n = 1;
    step(0, 0, 1, '1, 6'd3, '0);
    step(1, 1, 1, '1, '0, '0);
    step(1, 1, 1, '1, '0, '0);
    #2 chk(!dq_drive, "R9", {31'b0, dq_drive}, '0);
    oe_n = 0;
    #1 chk(dq_drive && dq_out == model[3], "R9", dq_out, model[3]);
    oe_n = 1;
    #1 chk(!dq_drive, "R9", {31'b0, dq_drive}, '0);
    step(0, 1, 1, '1, '0, '0);
    oe_n = 0;
    due_q.delete(); dat_q.delete(); tag_q.delete();
    mon_en = 1;
    step(0, 1, 1, '1, '0, '0);
    step(0, 1, 1, '1, '0, '0);

    mon_en = 0;
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule